// File: doc/BRIEF.md
# NAND Flash Host Register Interface with Inline ECC

This block sits between a simple processor register bus and a raw 8-bit NAND flash device. Software sets the command-latch, address-latch, write-protect and chip-enable pins by writing a control register, and reads the device ready/busy pin back through the same register. Data bytes move through a single I/O register: a write sends one byte to the device, a byte read fetches one byte, and a 32-bit read fetches two bytes in succession.

Every byte that crosses the I/O register, in either direction, is fed to an ECC accumulator of the usual 256-byte Hamming form. Software reads the column parity, two interleaved line-parity bytes and a byte counter, and resets all of them with a write to a clear register. Each bus access is a one-cycle request answered by a one-cycle acknowledge; I/O accesses take longer because they strobe the device.

Top module: `nand_host_regs`

## Requirements
- R1: After reset the control register holds 0, so `nand_ce_n` is 1, `nand_cle`, `nand_ale`, `nand_wp`, `nand_doe` and both strobes are 0, and the byte counter, column parity and both line-parity readouts read 0.
- R2: A write to offset 0x18 stores `bus_wdata` with bit 5 forced to 0; from the next cycle `nand_cle` follows stored bit 1, `nand_ale` bit 2 and `nand_wp` bit 3.
- R3: `nand_ce_n` is 0 exactly when stored control bit 0 or bit 4 is 1.
- R4: A read of offset 0x18 returns the stored control byte with bit 5 replaced by the level of `nand_rb` at the request.
- R5: A write to offset 0x14 (either size) gives one cycle with `nand_wr_stb` and `nand_doe` high and `nand_dout` equal to the byte, and digests that byte.
- R6: A byte read of offset 0x14 gives one cycle with `nand_rd_stb` high, returns the sampled `nand_din` in bits 7:0 with all other bits 0, and digests that byte.
- R7: A 32-bit read of offset 0x14 strobes the device twice; the first byte lands in bits 15:0 and the second in bits 31:16 (each zero-extended), and both are digested.
- R8: Offset 0x08 returns, in bits 5:0, the column parity of X, the XOR of all digested bytes: bit 0 = XOR of X bits {0,2,4,6}, bit 1 = {1,3,5,7}, bit 2 = {0,1,4,5}, bit 3 = {2,3,6,7}, bit 4 = {0,1,2,3}, bit 5 = {4,5,6,7}.
- R9: Two 8-bit line parities are kept: for each digested byte with an odd number of ones, Z is XORed with the inverted byte index and N with the byte index (index = count before the byte). Offset 0x00 returns Z[k] in bit 2k and N[k] in bit 2k+1 for k = 0..3; offset 0x04 does the same with Z[k+4] and N[k+4].
- R10: Offset 0x0C returns the number of bytes digested since the last clear, modulo 256.
- R11: A write to offset 0x10, whatever its value, zeroes the counter and all parity state.
- R12: A read of any other offset returns 0; a write to any offset other than 0x10, 0x14 and 0x18 changes no state and causes no device strobe.
- R13: `bus_ack` rises 1 cycle after an accepted request for a register access, 2 cycles for an I/O write or byte read, and 3 cycles for a 32-bit I/O read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_req | input | 1 | Access request, accepted when the block is idle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_wide | input | 1 | 1 = 32-bit access, 0 = byte access |
| bus_addr | input | 5 | Byte offset of the register |
| bus_wdata | input | 8 | Write data |
| bus_ack | output | 1 | One-cycle completion pulse |
| bus_rdata | output | 32 | Read data, valid with `bus_ack` |
| nand_cle | output | 1 | Command latch enable |
| nand_ale | output | 1 | Address latch enable |
| nand_ce_n | output | 1 | Chip enable, active low |
| nand_wp | output | 1 | Write-protect control bit |
| nand_rb | input | 1 | Device ready (1) / busy (0) |
| nand_din | input | 8 | Data from device |
| nand_dout | output | 8 | Data to device |
| nand_doe | output | 1 | Drive enable for `nand_dout` |
| nand_rd_stb | output | 1 | One-cycle device read strobe; `nand_din` sampled at its end |
| nand_wr_stb | output | 1 | One-cycle device write strobe |

## Verification
The accumulator is fed single bytes of odd and even weight, runs mixing writes with byte and 32-bit reads, and a run longer than 256 bytes: odd-weight bytes separate the line-parity path from the column path, the mixed run shows reads and writes are digested alike and in order, and the long run shows the counter and byte index wrap together. Control writes with all bits set, each chip-enable bit alone and none set separate the OR of the two enables from either one, and reads with the ready pin low and high show bit 5 is live rather than stored. Clear with a non-zero value, writes to read-only and undefined offsets, and latency counting on every access finish the set.

// File: rtl/nand_host_pkg.sv
// Package: shared offsets, control bit positions and the host state type
// for the NAND host register block. Assumes a 5-bit byte offset bus.
package nand_host_pkg;
    localparam int ADDR_W = 5;

    localparam logic [ADDR_W-1:0] OFS_LP_LO = 5'h00;
    localparam logic [ADDR_W-1:0] OFS_LP_HI = 5'h04;
    localparam logic [ADDR_W-1:0] OFS_COL   = 5'h08;
    localparam logic [ADDR_W-1:0] OFS_CNT   = 5'h0C;
    localparam logic [ADDR_W-1:0] OFS_CLR   = 5'h10;
    localparam logic [ADDR_W-1:0] OFS_IO    = 5'h14;
    localparam logic [ADDR_W-1:0] OFS_CTL   = 5'h18;

    localparam int CTL_CE0 = 0;
    localparam int CTL_CLE = 1;
    localparam int CTL_ALE = 2;
    localparam int CTL_WP  = 3;
    localparam int CTL_CE1 = 4;
    localparam int CTL_RB  = 5;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_RD0,
        ST_RD1,
        ST_WR
    } host_state_e;
endpackage

// File: rtl/nand_ecc_acc.sv
// Running Hamming accumulator. Keeps the XOR of all digested bytes, two
// line-parity registers (index and inverted index of odd-weight bytes)
// and a byte counter whose value is the index of the next byte.
// Assumes clr and dig_en are never high in the same cycle.
module nand_ecc_acc #(
    parameter int BYTE_W = 8,
    parameter int IDX_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              dig_en,
    input  logic [BYTE_W-1:0] dig_byte,
    output logic [IDX_W-1:0]  par_zero,
    output logic [IDX_W-1:0]  par_one,
    output logic [BYTE_W-1:0] col_acc,
    output logic [IDX_W-1:0]  byte_cnt
);
    // Accumulate parity and count per digested byte; clear on request.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            par_zero <= '0;
            par_one  <= '0;
            col_acc  <= '0;
            byte_cnt <= '0;
        end else if (dig_en) begin
            byte_cnt <= byte_cnt + 1'b1;
            col_acc  <= col_acc ^ dig_byte;
            if (^dig_byte) begin
                par_one  <= par_one ^ byte_cnt;
                par_zero <= par_zero ^ ~byte_cnt;
            end
        end
    end
endmodule

// File: rtl/nand_col_par.sv
// Column parity from the XOR of all bytes. For each bit g of the bit
// position, output 2g covers positions with that bit 0 and output 2g+1
// covers positions with it 1. Assumes BYTE_W is a power of two.
module nand_col_par #(
    parameter int BYTE_W = 8,
    localparam int POS_W = $clog2(BYTE_W),
    localparam int CP_W  = 2 * POS_W
) (
    input  logic [BYTE_W-1:0] col_acc,
    output logic [CP_W-1:0]   col_par
);
    for (genvar g = 0; g < POS_W; g++) begin : g_grp
        // Fold the bits of one position group into its two parity bits.
        always_comb begin
            col_par[2*g]   = 1'b0;
            col_par[2*g+1] = 1'b0;
            for (int p = 0; p < BYTE_W; p++) begin
                if (((p >> g) & 1) == 0) col_par[2*g]   = col_par[2*g]   ^ col_acc[p];
                else                     col_par[2*g+1] = col_par[2*g+1] ^ col_acc[p];
            end
        end
    end
endmodule

// File: rtl/nand_lp_weave.sv
// Interleaves two line-parity registers into two readout bytes: the
// zero-side register fills even bits, the one-side register odd bits;
// the low readout uses the lower halves, the high readout the upper.
module nand_lp_weave #(
    parameter int IDX_W = 8,
    localparam int HALF = IDX_W / 2
) (
    input  logic [IDX_W-1:0] par_zero,
    input  logic [IDX_W-1:0] par_one,
    output logic [IDX_W-1:0] lp_lo,
    output logic [IDX_W-1:0] lp_hi
);
    for (genvar k = 0; k < HALF; k++) begin : g_bit
        assign lp_lo[2*k]   = par_zero[k];
        assign lp_lo[2*k+1] = par_one[k];
        assign lp_hi[2*k]   = par_zero[k+HALF];
        assign lp_hi[2*k+1] = par_one[k+HALF];
    end
endmodule

// File: rtl/nand_host_regs.sv
// NAND host register block. Decodes one-cycle bus requests, holds the
// pin control byte, sequences device byte strobes for the I/O register
// and feeds every transferred byte to the ECC accumulator.
// Assumes requests arriving while busy are dropped by the requester
// waiting for bus_ack, and that nand_din is valid during nand_rd_stb.
module nand_host_regs
    import nand_host_pkg::*;
#(
    parameter int BYTE_W = 8,
    parameter int IDX_W  = 8,
    parameter int WORD_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_req,
    input  logic              bus_we,
    input  logic              bus_wide,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [BYTE_W-1:0] bus_wdata,
    output logic              bus_ack,
    output logic [WORD_W-1:0] bus_rdata,
    output logic              nand_cle,
    output logic              nand_ale,
    output logic              nand_ce_n,
    output logic              nand_wp,
    input  logic              nand_rb,
    input  logic [BYTE_W-1:0] nand_din,
    output logic [BYTE_W-1:0] nand_dout,
    output logic              nand_doe,
    output logic              nand_rd_stb,
    output logic              nand_wr_stb
);
    localparam int HALF_W = WORD_W / 2;
    localparam int CP_W   = 2 * $clog2(BYTE_W);
    localparam logic [BYTE_W-1:0] RB_MASK = BYTE_W'(1) << CTL_RB;

    host_state_e       st;
    logic [BYTE_W-1:0] ctl_q;
    logic [BYTE_W-1:0] wbyte_q;
    logic [BYTE_W-1:0] first_q;
    logic              wide_q;
    logic              host_idle;
    logic              ecc_clr;
    logic              dig_en;
    logic [BYTE_W-1:0] dig_byte;
    logic [IDX_W-1:0]  par_zero;
    logic [IDX_W-1:0]  par_one;
    logic [BYTE_W-1:0] col_acc;
    logic [IDX_W-1:0]  byte_cnt;
    logic [CP_W-1:0]   col_par;
    logic [IDX_W-1:0]  lp_lo;
    logic [IDX_W-1:0]  lp_hi;
    logic [WORD_W-1:0] reg_rd_val;

    assign host_idle = (st == ST_IDLE);
    assign ecc_clr   = bus_req && host_idle && bus_we && (bus_addr == OFS_CLR);
    assign dig_en    = (st == ST_RD0) || (st == ST_RD1) || (st == ST_WR);
    assign dig_byte  = (st == ST_WR) ? wbyte_q : nand_din;

    nand_ecc_acc #(.BYTE_W(BYTE_W), .IDX_W(IDX_W)) i_ecc (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (ecc_clr),
        .dig_en   (dig_en),
        .dig_byte (dig_byte),
        .par_zero (par_zero),
        .par_one  (par_one),
        .col_acc  (col_acc),
        .byte_cnt (byte_cnt)
    );

    nand_col_par #(.BYTE_W(BYTE_W)) i_col (
        .col_acc (col_acc),
        .col_par (col_par)
    );

    nand_lp_weave #(.IDX_W(IDX_W)) i_weave (
        .par_zero (par_zero),
        .par_one  (par_one),
        .lp_lo    (lp_lo),
        .lp_hi    (lp_hi)
    );

    // Select the read value of a non-I/O register; undefined offsets give 0.
    always_comb begin
        case (bus_addr)
            OFS_LP_LO: reg_rd_val = WORD_W'(lp_lo);
            OFS_LP_HI: reg_rd_val = WORD_W'(lp_hi);
            OFS_COL:   reg_rd_val = WORD_W'(col_par);
            OFS_CNT:   reg_rd_val = WORD_W'(byte_cnt);
            OFS_CTL:   reg_rd_val = WORD_W'((ctl_q & ~RB_MASK) | (nand_rb ? RB_MASK : '0));
            default:   reg_rd_val = '0;
        endcase
    end

    // Accept requests, sequence device strobes and produce the acknowledge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st        <= ST_IDLE;
            ctl_q     <= '0;
            wbyte_q   <= '0;
            first_q   <= '0;
            wide_q    <= 1'b0;
            bus_ack   <= 1'b0;
            bus_rdata <= '0;
        end else begin
            bus_ack <= 1'b0;
            case (st)
                ST_IDLE: begin
                    if (bus_req) begin
                        if (bus_addr == OFS_IO) begin
                            if (bus_we) begin
                                wbyte_q <= bus_wdata;
                                st      <= ST_WR;
                            end else begin
                                wide_q <= bus_wide;
                                st     <= ST_RD0;
                            end
                        end else begin
                            bus_ack <= 1'b1;
                            if (bus_we) begin
                                bus_rdata <= '0;
                                if (bus_addr == OFS_CTL) ctl_q <= bus_wdata & ~RB_MASK;
                            end else begin
                                bus_rdata <= reg_rd_val;
                            end
                        end
                    end
                end
                ST_RD0: begin
                    first_q <= nand_din;
                    if (wide_q) begin
                        st <= ST_RD1;
                    end else begin
                        bus_ack   <= 1'b1;
                        bus_rdata <= WORD_W'(nand_din);
                        st        <= ST_IDLE;
                    end
                end
                ST_RD1: begin
                    bus_ack   <= 1'b1;
                    bus_rdata <= {{(HALF_W-BYTE_W){1'b0}}, nand_din,
                                  {(HALF_W-BYTE_W){1'b0}}, first_q};
                    st        <= ST_IDLE;
                end
                default: begin
                    bus_ack   <= 1'b1;
                    bus_rdata <= '0;
                    st        <= ST_IDLE;
                end
            endcase
        end
    end

    assign nand_cle    = ctl_q[CTL_CLE];
    assign nand_ale    = ctl_q[CTL_ALE];
    assign nand_wp     = ctl_q[CTL_WP];
    assign nand_ce_n   = !(ctl_q[CTL_CE0] || ctl_q[CTL_CE1]);
    assign nand_dout   = wbyte_q;
    assign nand_doe    = (st == ST_WR);
    assign nand_wr_stb = (st == ST_WR);
    assign nand_rd_stb = (st == ST_RD0) || (st == ST_RD1);
endmodule

// File: rtl/nand_host_chk.sv
// Checker for nand_host_regs: relates bus requests to pin, counter and
// read-data behaviour. Attached through the bind at the end of this file.
module nand_host_chk
    import nand_host_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              bus_req,
    input logic              bus_we,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [7:0]        bus_wdata,
    input logic              host_idle,
    input logic              bus_ack,
    input logic [31:0]       bus_rdata,
    input logic              nand_cle,
    input logic              nand_ale,
    input logic              nand_wp,
    input logic              nand_ce_n,
    input logic              nand_rd_stb,
    input logic              nand_wr_stb,
    input logic [7:0]        byte_cnt,
    input logic [7:0]        par_zero,
    input logic [7:0]        par_one
);
    logic ctl_wr;
    logic clr_wr;
    assign ctl_wr = bus_req && bus_we && host_idle && (bus_addr == OFS_CTL);
    assign clr_wr = bus_req && bus_we && host_idle && (bus_addr == OFS_CLR);

    a_r2_ctl_pins: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_wr |=> (nand_cle == $past(bus_wdata[1]) && nand_ale == $past(bus_wdata[2])
                    && nand_wp == $past(bus_wdata[3])));

    a_r3_chip_enable: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_wr |=> (nand_ce_n == !($past(bus_wdata[0]) || $past(bus_wdata[4]))));

    a_r11_clear: assert property (@(posedge clk) disable iff (!rst_n)
        clr_wr |=> (byte_cnt == 8'd0 && par_zero == 8'd0 && par_one == 8'd0));

    a_r10_count_step: assert property (@(posedge clk) disable iff (!rst_n)
        (nand_rd_stb || nand_wr_stb) |=> (byte_cnt == 8'($past(byte_cnt) + 8'd1)));

    a_r12_cnt_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!nand_rd_stb && !nand_wr_stb && !clr_wr) |=> $stable(byte_cnt));

    a_r5_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({nand_rd_stb, nand_wr_stb}));

    a_r7_zero_pad: assert property (@(posedge clk) disable iff (!rst_n)
        bus_ack |-> (bus_rdata[15:8] == 8'd0 && bus_rdata[31:24] == 8'd0));
endmodule

bind nand_host_regs nand_host_chk i_nand_host_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .bus_req     (bus_req),
    .bus_we      (bus_we),
    .bus_addr    (bus_addr),
    .bus_wdata   (bus_wdata),
    .host_idle   (host_idle),
    .bus_ack     (bus_ack),
    .bus_rdata   (bus_rdata),
    .nand_cle    (nand_cle),
    .nand_ale    (nand_ale),
    .nand_wp     (nand_wp),
    .nand_ce_n   (nand_ce_n),
    .nand_rd_stb (nand_rd_stb),
    .nand_wr_stb (nand_wr_stb),
    .byte_cnt    (byte_cnt),
    .par_zero    (par_zero),
    .par_one     (par_one)
);

// File: tb/test_nand_host_regs.sv
`timescale 1ns/1ps
// Scoreboard bench: the driver pushes expected read data, the monitor
// pops and compares on each acknowledge; a small device model serves reads.
module test_nand_host_regs;
    import nand_host_pkg::*;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_req = 1'b0;
    logic        bus_we = 1'b0;
    logic        bus_wide = 1'b0;
    logic [4:0]  bus_addr = '0;
    logic [7:0]  bus_wdata = '0;
    logic        bus_ack;
    logic [31:0] bus_rdata;
    logic        nand_cle, nand_ale, nand_ce_n, nand_wp;
    logic        nand_rb = 1'b1;
    logic [7:0]  nand_din;
    logic [7:0]  nand_dout;
    logic        nand_doe, nand_rd_stb, nand_wr_stb;

    always #2.5 clk = ~clk;

    nand_host_regs i_nand_host_regs (
        .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_we(bus_we),
        .bus_wide(bus_wide), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_ack(bus_ack), .bus_rdata(bus_rdata), .nand_cle(nand_cle),
        .nand_ale(nand_ale), .nand_ce_n(nand_ce_n), .nand_wp(nand_wp),
        .nand_rb(nand_rb), .nand_din(nand_din), .nand_dout(nand_dout),
        .nand_doe(nand_doe), .nand_rd_stb(nand_rd_stb), .nand_wr_stb(nand_wr_stb)
    );

    // Device model: a read strobe consumes the current byte.
    logic [7:0] dev_mem [0:15];
    logic [3:0] dev_ptr;
    logic [7:0] dev_last;
    int         dev_wcount;
    assign nand_din = dev_mem[dev_ptr];
    always @(posedge clk) begin
        if (!rst_n) begin
            dev_ptr    <= '0;
            dev_last   <= '0;
            dev_wcount <= 0;
        end else begin
            if (nand_rd_stb) dev_ptr <= dev_ptr + 4'd1;
            if (nand_wr_stb) begin
                dev_last   <= nand_dout;
                dev_wcount <= dev_wcount + 1;
            end
        end
    end

    int n_checks = 0;
    int n_fail = 0;
    logic [31:0] exp_q[$];
    bit          chk_q[$];
    string       tag_q[$];

    // Bench ECC model built from R8..R10.
    logic [7:0] m_col = '0, m_zero = '0, m_one = '0, m_cnt = '0;
    logic [3:0] b_ptr = '0;

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic model_dig(input logic [7:0] b);
        if (^b) begin
            m_one  = m_one ^ m_cnt;
            m_zero = m_zero ^ ~m_cnt;
        end
        m_col = m_col ^ b;
        m_cnt = m_cnt + 8'd1;
    endtask

    function automatic logic [31:0] exp_col();
        return {26'd0, ^(m_col & 8'hF0), ^(m_col & 8'h0F), ^(m_col & 8'hCC),
                ^(m_col & 8'h33), ^(m_col & 8'hAA), ^(m_col & 8'h55)};
    endfunction

    function automatic logic [31:0] exp_lp(input bit upper);
        logic [3:0] z, n;
        z = upper ? m_zero[7:4] : m_zero[3:0];
        n = upper ? m_one[7:4]  : m_one[3:0];
        return {24'd0, n[3], z[3], n[2], z[2], n[1], z[1], n[0], z[0]};
    endfunction

    // Monitor: compare each acknowledged result against the queue head.
    always @(negedge clk) begin
        if (rst_n && bus_ack) begin
            if (exp_q.size() == 0) begin
                n_checks++;
                n_fail++;
                $display("FAIL R13 actual=ack expected=no ack");
            end else begin
                logic [31:0] e;
                bit c;
                string t;
                e = exp_q.pop_front();
                c = chk_q.pop_front();
                t = tag_q.pop_front();
                if (c) check(t, bus_rdata, e);
            end
        end
    end

    // Driver: issue one request, push its expectation, check latency (R13).
    task automatic access(input bit we, input bit wide, input logic [4:0] addr,
                          input logic [7:0] wd, input logic [31:0] exp,
                          input bit chk, input string tag, input int lat);
        int cyc;
        @(negedge clk);
        exp_q.push_back(exp);
        chk_q.push_back(chk);
        tag_q.push_back(tag);
        bus_req = 1'b1; bus_we = we; bus_wide = wide; bus_addr = addr; bus_wdata = wd;
        @(negedge clk);
        bus_req = 1'b0;
        cyc = 1;
        while (!bus_ack) begin
            @(negedge clk);
            cyc++;
        end
        if (lat > 0) check({"R13 latency ", tag}, cyc, lat);
    endtask

    task automatic reg_rd(input logic [4:0] addr, input logic [31:0] exp, input string tag);
        access(1'b0, 1'b0, addr, 8'h00, exp, 1'b1, tag, 1);
    endtask

    task automatic reg_wr(input logic [4:0] addr, input logic [7:0] wd);
        access(1'b1, 1'b0, addr, wd, 32'h0, 1'b0, "wr", 1);
    endtask

    task automatic io_wr(input logic [7:0] b, input bit lat_chk);
        access(1'b1, 1'b0, OFS_IO, b, 32'h0, 1'b0, "R5 io write", lat_chk ? 2 : 0);
        model_dig(b);
    endtask

    task automatic io_rd_byte();
        logic [7:0] e;
        e = dev_mem[b_ptr];
        b_ptr = b_ptr + 4'd1;
        access(1'b0, 1'b0, OFS_IO, 8'h00, {24'd0, e}, 1'b1, "R6 io byte read", 2);
        model_dig(e);
    endtask

    task automatic io_rd_word();
        logic [7:0] e1, e2;
        e1 = dev_mem[b_ptr];
        e2 = dev_mem[b_ptr + 4'd1];
        b_ptr = b_ptr + 4'd2;
        access(1'b0, 1'b1, OFS_IO, 8'h00, {8'd0, e2, 8'd0, e1}, 1'b1, "R7 io word read", 3);
        model_dig(e1);
        model_dig(e2);
    endtask

    task automatic ecc_check(input string tag);
        reg_rd(OFS_CNT, {24'd0, m_cnt}, {"R10 count ", tag});
        reg_rd(OFS_COL, exp_col(), {"R8 column parity ", tag});
        reg_rd(OFS_LP_LO, exp_lp(1'b0), {"R9 line parity low ", tag});
        reg_rd(OFS_LP_HI, exp_lp(1'b1), {"R9 line parity high ", tag});
    endtask

    task automatic ecc_clear(input logic [7:0] v);
        reg_wr(OFS_CLR, v);
        m_col = '0; m_zero = '0; m_one = '0; m_cnt = '0;
    endtask

    // Watchdog: an expired run counts as a failure and still reports.
    initial begin
        repeat (100000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end

    initial begin
        int wc;
        for (int i = 0; i < 16; i++) dev_mem[i] = 8'(8'h3C ^ (i * 37));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state at the pins and in the ECC readouts
        check("R1 ce_n", nand_ce_n, 1);
        check("R1 cle/ale/wp", {nand_cle, nand_ale, nand_wp}, 0);
        check("R1 strobes/doe", {nand_rd_stb, nand_wr_stb, nand_doe}, 0);
        ecc_check("after reset");

        // R2/R3/R4: control register
        reg_wr(OFS_CTL, 8'hFF);
        check("R2 pins after 0xFF", {nand_cle, nand_ale, nand_wp}, 3'b111);
        check("R3 ce_n after 0xFF", nand_ce_n, 0);
        nand_rb = 1'b0;
        reg_rd(OFS_CTL, 32'hDF, "R4 ctl read rb=0 (bit5 masked R2)");
        nand_rb = 1'b1;
        reg_rd(OFS_CTL, 32'hFF, "R4 ctl read rb=1");
        reg_wr(OFS_CTL, 8'h10);
        check("R3 ce_n CE1 only", nand_ce_n, 0);
        check("R2 pins after 0x10", {nand_cle, nand_ale, nand_wp}, 3'b000);
        reg_wr(OFS_CTL, 8'h01);
        check("R3 ce_n CE0 only", nand_ce_n, 0);
        reg_wr(OFS_CTL, 8'h02);
        check("R3 ce_n none", nand_ce_n, 1);
        check("R2 pins after 0x02", {nand_cle, nand_ale, nand_wp}, 3'b100);
        reg_wr(OFS_CTL, 8'h24);
        nand_rb = 1'b0;
        reg_rd(OFS_CTL, 32'h04, "R4 ctl read 0x24 stored, rb=0");
        nand_rb = 1'b1;
        check("R2 ale only", {nand_cle, nand_ale, nand_wp}, 3'b010);

        // R5: I/O writes reach the device and are digested
        wc = dev_wcount;
        io_wr(8'h5A, 1'b1);
        check("R5 device byte", dev_last, 8'h5A);
        io_wr(8'h01, 1'b1);
        check("R5 device byte", dev_last, 8'h01);
        access(1'b1, 1'b1, OFS_IO, 8'h80, 32'h0, 1'b0, "R5 io wide write", 2);
        model_dig(8'h80);
        check("R5 wide write byte", dev_last, 8'h80);
        io_wr(8'hFF, 1'b1);
        check("R5 write count", dev_wcount, wc + 4);
        ecc_check("after writes");

        // R6/R7: reads mixed with writes
        io_rd_byte();
        io_rd_byte();
        io_rd_word();
        io_wr(8'h07, 1'b1);
        io_rd_word();
        io_rd_byte();
        ecc_check("after mixed");

        // R11: clear with non-zero value
        ecc_clear(8'hA5);
        ecc_check("after clear");
        io_rd_byte();
        ecc_check("one byte after clear");

        // R12: undefined offsets and read-only writes
        reg_rd(5'h1C, 32'h0, "R12 undefined read");
        reg_rd(5'h02, 32'h0, "R12 misaligned read");
        reg_rd(OFS_CLR, 32'h0, "R12 clear reg read");
        wc = dev_wcount;
        reg_wr(5'h1C, 8'hFF);
        reg_wr(OFS_CNT, 8'h55);
        reg_wr(OFS_LP_LO, 8'hAA);
        reg_wr(OFS_COL, 8'h3F);
        reg_rd(OFS_CTL, 32'h24, "R12 ctl unchanged");
        check("R12 no device strobe", dev_wcount, wc);
        ecc_check("R12 after ignored writes");

        // R10: wrap of counter and byte index past 256
        ecc_clear(8'h00);
        for (int i = 0; i < 258; i++) io_wr(8'((i * 29) ^ 8'h6B), 1'b0);
        ecc_check("after wrap");

        repeat (4) @(negedge clk);
        check("R13 queue drained", exp_q.size(), 0);
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end
endmodule